// File: doc/BRIEF.md
# Single-Wire ROM Command Tracker

This block follows the addressing phase of a single-wire bus from a stream of link-layer events that another block has already decoded. Each cycle it may receive a bus reset event or one received bit with its value. After every bus reset it gathers an eight-bit ROM command. The command decides what comes next: a plain 64-bit device address, a 64-bit address search, or a direct move to the transport phase. Transport data that follows is grouped into bytes.

For a search, each address position takes three slots. Slaves send the true bit, then slaves send its complement, then the master writes the chosen direction. The direction bit becomes the address bit. The block keeps the true and complement vectors. It raises a flag when some position shows both as one, because that means no device answered. The decoded command, the assembled address and each transport byte are each reported with a one-cycle strobe. CRC checking and the meaning of transport bytes are handled elsewhere.

Top module: `owt_rom_tracker`

## Requirements
- R1: After `rst`, `cmd_valid`, `rom_valid`, `byte_valid` and `search_nodev` are all 0, and the tracker waits for a command.
- R2: In the command phase, eight bit events are taken least significant bit first. `cmd_valid` is high in the cycle after the clock edge that takes the eighth bit, and `cmd_code` holds the byte. No strobe comes earlier.
- R3: Commands 0x33, 0x0F, 0x55 and 0x69 make the next 64 bits a plain address, least significant bit first (bit 0 is the first bit received). `rom_valid` strobes after the 64th bit, with the address on `rom_addr`.
- R4: Commands 0xCC and 0x3C go straight to the transport phase. The next eight bits produce `byte_valid`, and no `rom_valid` is raised.
- R5: Commands 0xF0 and 0xEC start a search of 64 triplets in the order true bit, complement bit, direction bit. The direction bits, least significant first, form `rom_addr`. `rom_valid` strobes after the 192nd slot.
- R6: During a search, `search_nodev` goes to 1 after the complement slot of any position whose true and complement bits were both 1. It stays at 1 until the next bus reset event, which clears it.
- R7: After an address has been captured, by read or by search, every further group of eight bits gives one `byte_valid` strobe, with the byte least significant bit first on `byte_data`.
- R8: Any other command byte is still reported on `cmd_valid`. After that, all bits are ignored and no strobe occurs until the next bus reset event.
- R9: A bus reset event in any phase drops partial data and returns the tracker to the command phase. A bit event in the same cycle as a bus reset event is discarded.
- R10: Each strobe lasts exactly one cycle, and at most one of the three strobes is high in any cycle.
- R11: Cycles without a bit event do not change the result, so bits may arrive with any number of idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_rst | input | 1 | Bus reset event strobe from the link layer |
| link_bit | input | 1 | Received bit event strobe |
| link_val | input | 1 | Value of the received bit, valid with `link_bit` |
| cmd_valid | output | 1 | One-cycle strobe: ROM command complete |
| cmd_code | output | 8 | Last ROM command byte |
| rom_valid | output | 1 | One-cycle strobe: 64-bit address complete |
| rom_addr | output | ROM_W | Last captured device address |
| byte_valid | output | 1 | One-cycle strobe: transport byte complete |
| byte_data | output | 8 | Last transport byte |
| search_nodev | output | 1 | No-responder flag from the current search |

## Verification
The situation hardest to reach from the ports is a search in which one position reports both the true and the complement bit as one. The no-responder flag must rise exactly after that complement slot and then survive the rest of the search and the transport bytes. The stimulus therefore drives full 192-slot searches in which a chosen position carries 1/1. It samples the flag after every complement slot, both before and after that position, and finally issues a bus reset to see the flag clear. A second hard case is a reset event in the same cycle as a bit event. The bench places one in the middle of a command and then checks that the next command is assembled without a shifted bit.

// File: rtl/owt_pkg.sv
package owt_pkg;

    localparam int unsigned OP_W = 8;

    localparam logic [OP_W-1:0] OP_READ      = 8'h33;
    localparam logic [OP_W-1:0] OP_CREAD     = 8'h0F;
    localparam logic [OP_W-1:0] OP_MATCH     = 8'h55;
    localparam logic [OP_W-1:0] OP_OD_MATCH  = 8'h69;
    localparam logic [OP_W-1:0] OP_SEARCH    = 8'hF0;
    localparam logic [OP_W-1:0] OP_CSEARCH   = 8'hEC;
    localparam logic [OP_W-1:0] OP_SKIP      = 8'hCC;
    localparam logic [OP_W-1:0] OP_OD_SKIP   = 8'h3C;

    // Phases of the addressing sequence
    typedef enum logic [2:0] {
        PH_CMD,
        PH_ROM,
        PH_SEARCH,
        PH_XFER,
        PH_IDLE
    } phase_e;

    // Slot inside one search triplet
    typedef enum logic [1:0] {
        SLOT_TRUE,
        SLOT_COMP,
        SLOT_DIR
    } slot_e;

    // One link-layer event
    typedef struct packed {
        logic rst_ev;
        logic bit_ev;
        logic bit_val;
    } link_ev_t;

    // Phase entered once a command byte is complete
    function automatic phase_e phase_after(input logic [OP_W-1:0] op);
        phase_e nx;
        case (op)
            OP_READ, OP_CREAD, OP_MATCH, OP_OD_MATCH: nx = PH_ROM;
            OP_SEARCH, OP_CSEARCH:                    nx = PH_SEARCH;
            OP_SKIP, OP_OD_SKIP:                      nx = PH_XFER;
            default:                                  nx = PH_IDLE;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/owt_shift_collect.sv
module owt_shift_collect #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         take,
    input  logic         din,
    output logic         last,
    output logic [W-1:0] word
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;

    // LSB first: newest bit enters at the top and moves down
    assign word = {din, sh[W-1:1]};
    assign last = take && (cnt == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (take) begin
            sh <= word;
        end
    end

endmodule

// File: rtl/owt_search_collect.sv
module owt_search_collect
    import owt_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         take,
    input  logic         din,
    output logic         last,
    output logic [W-1:0] word,
    output logic         nodev
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

    slot_e         slot;
    logic [CW-1:0] pos;
    logic          t_hold;
    logic [W-1:0]  true_v;
    logic [W-1:0]  comp_v;
    logic [W-1:0]  dir_v;

    assign word  = {din, dir_v[W-1:1]};
    assign last  = take && (slot == SLOT_DIR) && (pos == CW'(W - 1));
    assign nodev = |(true_v & comp_v);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            slot   <= SLOT_TRUE;
            pos    <= '0;
            t_hold <= 1'b0;
            true_v <= '0;
            comp_v <= '0;
        end else if (take) begin
            case (slot)
                SLOT_TRUE: begin
                    t_hold <= din;
                    slot   <= SLOT_COMP;
                end
                SLOT_COMP: begin
                    // true and complement of one position shift in together
                    true_v <= {t_hold, true_v[W-1:1]};
                    comp_v <= {din, comp_v[W-1:1]};
                    slot   <= SLOT_DIR;
                end
                SLOT_DIR: begin
                    slot <= SLOT_TRUE;
                    pos  <= last ? '0 : pos + 1'b1;
                end
                default: slot <= SLOT_TRUE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_v <= '0;
        end else if (take && (slot == SLOT_DIR)) begin
            dir_v <= word;
        end
    end

endmodule

// File: rtl/owt_phase_ctrl.sv
module owt_phase_ctrl
    import owt_pkg::*;
#(
    parameter int unsigned ROM_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  link_ev_t         ev,
    input  logic             byte_last,
    input  logic [OP_W-1:0]  byte_word,
    input  logic             rom_last,
    input  logic [ROM_W-1:0] rom_word,
    input  logic             srch_last,
    input  logic [ROM_W-1:0] srch_word,
    output logic             clr_all,
    output logic             take_byte,
    output logic             take_rom,
    output logic             take_srch,
    output logic             cmd_valid,
    output logic [OP_W-1:0]  cmd_code,
    output logic             rom_valid,
    output logic [ROM_W-1:0] rom_addr,
    output logic             byte_valid,
    output logic [OP_W-1:0]  byte_data
);
    phase_e phase;
    logic   bit_go;

    // a bus reset event overrides a bit event in the same cycle
    assign bit_go    = ev.bit_ev && !ev.rst_ev;
    assign clr_all   = ev.rst_ev;
    assign take_byte = bit_go && ((phase == PH_CMD) || (phase == PH_XFER));
    assign take_rom  = bit_go && (phase == PH_ROM);
    assign take_srch = bit_go && (phase == PH_SEARCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_CMD;
            cmd_valid  <= 1'b0;
            rom_valid  <= 1'b0;
            byte_valid <= 1'b0;
            cmd_code   <= '0;
            rom_addr   <= '0;
            byte_data  <= '0;
        end else begin
            cmd_valid  <= 1'b0;
            rom_valid  <= 1'b0;
            byte_valid <= 1'b0;
            if (ev.rst_ev) begin
                phase <= PH_CMD;
            end else begin
                case (phase)
                    PH_CMD: if (byte_last) begin
                        cmd_valid <= 1'b1;
                        cmd_code  <= byte_word;
                        phase     <= phase_after(byte_word);
                    end
                    PH_ROM: if (rom_last) begin
                        rom_valid <= 1'b1;
                        rom_addr  <= rom_word;
                        phase     <= PH_XFER;
                    end
                    PH_SEARCH: if (srch_last) begin
                        rom_valid <= 1'b1;
                        rom_addr  <= srch_word;
                        phase     <= PH_XFER;
                    end
                    PH_XFER: if (byte_last) begin
                        byte_valid <= 1'b1;
                        byte_data  <= byte_word;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/owt_rom_tracker.sv
module owt_rom_tracker
    import owt_pkg::*;
#(
    parameter int unsigned ROM_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_rst,
    input  logic             link_bit,
    input  logic             link_val,
    output logic             cmd_valid,
    output logic [7:0]       cmd_code,
    output logic             rom_valid,
    output logic [ROM_W-1:0] rom_addr,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic             search_nodev
);
    link_ev_t          ev;
    logic              clr_all;
    logic              take_byte;
    logic              take_rom;
    logic              take_srch;
    logic              byte_last;
    logic [OP_W-1:0]   byte_word;
    logic              rom_last;
    logic [ROM_W-1:0]  rom_word;
    logic              srch_last;
    logic [ROM_W-1:0]  srch_word;

    assign ev = '{rst_ev: link_rst, bit_ev: link_bit, bit_val: link_val};

    // shared by the command byte and the transport bytes
    owt_shift_collect #(.W(OP_W)) byte_col_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_all),
        .take (take_byte),
        .din  (ev.bit_val),
        .last (byte_last),
        .word (byte_word)
    );

    owt_shift_collect #(.W(ROM_W)) rom_col_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_all),
        .take (take_rom),
        .din  (ev.bit_val),
        .last (rom_last),
        .word (rom_word)
    );

    owt_search_collect #(.W(ROM_W)) srch_col_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_all),
        .take  (take_srch),
        .din   (ev.bit_val),
        .last  (srch_last),
        .word  (srch_word),
        .nodev (search_nodev)
    );

    owt_phase_ctrl #(.ROM_W(ROM_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .byte_last  (byte_last),
        .byte_word  (byte_word),
        .rom_last   (rom_last),
        .rom_word   (rom_word),
        .srch_last  (srch_last),
        .srch_word  (srch_word),
        .clr_all    (clr_all),
        .take_byte  (take_byte),
        .take_rom   (take_rom),
        .take_srch  (take_srch),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .rom_valid  (rom_valid),
        .rom_addr   (rom_addr),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

endmodule

// File: rtl/owt_rom_tracker_chk.sv
module owt_rom_tracker_chk (
    input logic clk,
    input logic rst,
    input logic link_rst,
    input logic link_bit,
    input logic cmd_valid,
    input logic rom_valid,
    input logic byte_valid,
    input logic search_nodev
);
    logic any_stb;
    assign any_stb = cmd_valid || rom_valid || byte_valid;

    // R10
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_valid, rom_valid, byte_valid}));

    // R10
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        any_stb |=> !any_stb);

    // R2
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        any_stb |-> $past(link_bit && !link_rst));

    // R9
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        link_rst |=> !any_stb);

    // R6
    nodev_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(search_nodev) |-> $past(link_rst));

endmodule

bind owt_rom_tracker owt_rom_tracker_chk chk_i (.*);

// File: tb/owt_rom_tracker_tb.sv
`timescale 1ns/1ps
module owt_rom_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_rst = 1'b0;
    logic        link_bit = 1'b0;
    logic        link_val = 1'b0;
    logic        cmd_valid, rom_valid, byte_valid, search_nodev;
    logic [7:0]  cmd_code, byte_data;
    logic [63:0] rom_addr;

    int n_chk = 0;
    int n_err = 0;
    int gap   = 0;

    always #2 clk = ~clk;

    owt_rom_tracker #(.ROM_W(64)) dut_i (
        .clk(clk), .rst(rst), .link_rst(link_rst), .link_bit(link_bit),
        .link_val(link_val), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .rom_valid(rom_valid), .rom_addr(rom_addr), .byte_valid(byte_valid),
        .byte_data(byte_data), .search_nodev(search_nodev)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic v, output logic [2:0] stb);
        @(negedge clk);
        link_bit = 1'b1;
        link_val = v;
        @(posedge clk);
        #1;
        stb = {cmd_valid, rom_valid, byte_valid};
        link_bit = 1'b0;
        repeat (gap) @(posedge clk);
    endtask

    // strobe code: 3'b100 cmd, 3'b010 rom, 3'b001 byte
    task automatic send_word(input logic [63:0] w, input int n,
                             input logic [2:0] exp_last, input string req);
        logic [2:0] s;
        logic [2:0] fin;
        int early;
        early = 0;
        fin   = '0;
        for (int i = 0; i < n; i++) begin
            send_bit(w[i], s);
            if (i < n - 1 && s != 3'b000) early++;
            if (i == n - 1) fin = s;
        end
        check_eq(req, "strobes before last bit", 64'(early), 64'd0);
        check_eq(req, "strobe after last bit", 64'(fin), 64'(exp_last));
    endtask

    task automatic bus_reset();
        @(negedge clk);
        link_rst = 1'b1;
        @(posedge clk);
        #1;
        link_rst = 1'b0;
    endtask

    task automatic t_reset_state();
        check_eq("R1", "strobes after rst", 64'({cmd_valid, rom_valid, byte_valid}), 64'd0);
        check_eq("R1", "nodev after rst", 64'(search_nodev), 64'd0);
    endtask

    task automatic t_skip(input logic [7:0] op, input logic [7:0] b0, input logic [7:0] b1);
        bus_reset();
        send_word(64'(op), 8, 3'b100, "R2");
        check_eq("R2", "command code", 64'(cmd_code), 64'(op));
        @(posedge clk); #1;
        check_eq("R10", "strobe one cycle", 64'({cmd_valid, rom_valid, byte_valid}), 64'd0);
        send_word(64'(b0), 8, 3'b001, "R4");
        check_eq("R4", "byte after skip", 64'(byte_data), 64'(b0));
        send_word(64'(b1), 8, 3'b001, "R7");
        check_eq("R7", "second byte", 64'(byte_data), 64'(b1));
    endtask

    task automatic t_read(input logic [7:0] op, input logic [63:0] addr, input logic [7:0] b0);
        bus_reset();
        send_word(64'(op), 8, 3'b100, "R2");
        send_word(addr, 64, 3'b010, "R3");
        check_eq("R3", "read address", rom_addr, addr);
        send_word(64'(b0), 8, 3'b001, "R7");
        check_eq("R7", "byte after read", 64'(byte_data), 64'(b0));
    endtask

    task automatic t_search(input logic [7:0] op, input logic [63:0] addr, input int cpos);
        logic [2:0] s;
        int early;
        int flag_bad;
        logic [2:0] fin;
        logic tb_bit, cb_bit;
        early = 0; flag_bad = 0; fin = '0;
        bus_reset();
        send_word(64'(op), 8, 3'b100, "R2");
        for (int i = 0; i < 64; i++) begin
            tb_bit = (i == cpos) ? 1'b1 : addr[i];
            cb_bit = (i == cpos) ? 1'b1 : ~addr[i];
            send_bit(tb_bit, s);
            if (s != 3'b000) early++;
            send_bit(cb_bit, s);
            if (s != 3'b000) early++;
            if (search_nodev !== ((cpos >= 0) && (i >= cpos))) flag_bad++;
            send_bit(addr[i], s);
            if (i < 63 && s != 3'b000) early++;
            if (i == 63) fin = s;
        end
        check_eq("R5", "strobes before last slot", 64'(early), 64'd0);
        check_eq("R5", "strobe after slot 192", 64'(fin), 64'b010);
        check_eq("R5", "search address", rom_addr, addr);
        check_eq("R6", "nodev per position", 64'(flag_bad), 64'd0);
        send_word(64'h96, 8, 3'b001, "R7");
        check_eq("R7", "byte after search", 64'(byte_data), 64'h96);
        check_eq("R6", "nodev held in transport", 64'(search_nodev), 64'(cpos >= 0));
        bus_reset();
        check_eq("R6", "nodev cleared by bus reset", 64'(search_nodev), 64'd0);
    endtask

    task automatic t_unknown();
        bus_reset();
        send_word(64'h00, 8, 3'b100, "R8");
        check_eq("R8", "unknown code reported", 64'(cmd_code), 64'h00);
        send_word(64'hFFFF_0000_CCCC_3333, 64, 3'b000, "R8");
        send_word(64'h55, 8, 3'b000, "R8");
        t_skip(8'hCC, 8'h11, 8'h22);
    endtask

    task automatic t_abort();
        logic [2:0] s;
        bus_reset();
        send_word(64'h55, 8, 3'b100, "R9");
        send_word(64'h1234_5678, 30, 3'b000, "R9");
        t_skip(8'hCC, 8'h7E, 8'h81);
        // reset and bit in one cycle: the bit must be dropped
        bus_reset();
        send_bit(1'b1, s);
        send_bit(1'b1, s);
        send_bit(1'b0, s);
        @(negedge clk);
        link_rst = 1'b1;
        link_bit = 1'b1;
        link_val = 1'b1;
        @(posedge clk); #1;
        link_rst = 1'b0;
        link_bit = 1'b0;
        send_word(64'hF0, 8, 3'b100, "R9");
        check_eq("R9", "command after merged reset", 64'(cmd_code), 64'hF0);
    endtask

    initial begin : main
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset_state();
        t_skip(8'hCC, 8'hA5, 8'h3B);
        t_skip(8'h3C, 8'h01, 8'h80);
        t_read(8'h33, 64'h8E00_0012_3456_7828, 8'h5A);
        t_read(8'h0F, 64'h0123_4567_89AB_CDEF, 8'hC3);
        t_read(8'h55, 64'hFEDC_BA98_7654_3210, 8'h0F);
        t_read(8'h69, 64'h8000_0000_0000_0001, 8'hF0);
        t_search(8'hF0, 64'hA5A5_0F0F_3C3C_9669, -1);
        t_search(8'hEC, 64'h0000_FFFF_1234_4321, 17);
        t_search(8'hF0, 64'h1111_2222_3333_4444, 63);
        t_unknown();
        t_abort();
        // R11: idle cycles between bits
        gap = 3;
        t_read(8'h55, 64'hDEAD_BEEF_0BAD_F00D, 8'h6C);
        check_eq("R11", "address with gaps", rom_addr, 64'hDEAD_BEEF_0BAD_F00D);
        gap = 0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule